// File: doc/BRIEF.md
# Little-endian byte memory port with instruction fetch

This block is the memory of a 64-bit core. It holds a byte-wide storage array and answers two request streams. The fetch stream reads 32-bit instruction words at the program counter. The data stream performs loads and stores of 1, 2, 4 or 8 bytes. Every physical address is rebased by subtracting a fixed base, 0x80000000, and the result is used as the byte index.

Loads are assembled byte by byte in little-endian order and returned right-aligned and zero-extended. Sign extension is left to the consumer. Stores split the low bytes of the store value across consecutive locations.

Each accepted request gets a registered response one cycle later, flagged by a valid strobe. A store lands on the same clock edge that accepts it. An access that does not fit inside the array raises a fault flag and is dropped. A size code the block does not support returns a fixed value of 1. The block also reports the initial stack pointer, which is one byte past the end of the array.

Top module: `lemp_port`

## Requirements
- R1: A data load with size code 0, 1, 2 or 3 reads 1, 2, 4 or 8 bytes from index (address − 0x80000000). The byte at the lowest address is returned in bits 7:0, the next in bits 15:8, and so on.
- R2: Load data is zero-extended: every bit above the accessed width reads 0.
- R3: A store of size code s writes only the low 2^s bytes of the store value, least significant byte at the lowest address. All other bytes keep their contents. The store response carries data 0 and no fault.
- R4: A size code from 4 to 7 is unsupported. A load with such a code returns 1 with no fault. A store with such a code returns 0 and changes no byte.
- R5: An access faults when its address is below 0x80000000, or when (address − 0x80000000) + byte count exceeds the capacity. A faulting access returns data 0 with the fault flag high and writes nothing.
- R6: A fetch returns the 32-bit little-endian word at the program counter and follows the same range rule with a byte count of 4. A faulting fetch returns 0 with its fault flag high.
- R7: A response's valid strobe is high exactly in the cycle after the request. A store is visible to requests from the next cycle on. A fetch or load issued in the same cycle as a store sees the contents from before that store.
- R8: The stack-top output equals 0x80000000 plus the capacity in bytes.
- R9: After reset, both valid strobes and both fault flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request |
| fetch_pc | input | 64 | Fetch address |
| fetch_vld | output | 1 | Fetch response valid |
| fetch_insn | output | 32 | Fetched word |
| fetch_fault | output | 1 | Fetch out of range |
| dat_req | input | 1 | Data request |
| dat_we | input | 1 | 1 = store, 0 = load |
| dat_addr | input | 64 | Data address |
| dat_size | input | 3 | Size code: 0..3 select 1, 2, 4 or 8 bytes |
| dat_wdata | input | 64 | Store value |
| dat_vld | output | 1 | Data response valid |
| dat_rdata | output | 64 | Load result |
| dat_fault | output | 1 | Data access out of range |
| stack_top | output | 64 | Initial stack pointer value |

## Verification
The bench aims at the range edges:
- the byte just below the base,
- a doubleword ending exactly at the top,
- one that overruns the top by a byte.

A design with an off-by-one in the limit would fault the last legal access, or would silently wrap and corrupt the bottom of memory.

Byte order is checked with distinct byte values. A design with swapped lanes returns a permuted word, and a design without zero-extension leaks neighbouring bytes into the upper bits.

Unsupported size codes and stores that collide with a fetch are also driven. A design that wrote on an unsupported store, or that forwarded new store data to a read in the same cycle, returns values that differ from the reference model.

// File: rtl/lemp_pkg.sv
package lemp_pkg;
  localparam int unsigned LANES = 8;
  typedef logic [2:0] size_code_t;

  // 0..3 select 1, 2, 4, 8 bytes; all other codes are unsupported
  function automatic logic size_ok(size_code_t c);
    return (c[2] == 1'b0);
  endfunction

  function automatic logic [3:0] size_bytes(size_code_t c);
    logic [3:0] n;
    case (c)
      3'd0:    n = 4'd1;
      3'd1:    n = 4'd2;
      3'd2:    n = 4'd4;
      3'd3:    n = 4'd8;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  localparam logic [63:0] BAD_SIZE_CODE = 64'd1;
endpackage

// File: rtl/lemp_range.sv
module lemp_range #(
  parameter logic [63:0] BASE  = 64'h8000_0000,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [63:0]      addr,
  input  logic [3:0]       nbytes,
  output logic             in_range,
  output logic [IDX_W-1:0] idx
);
  logic [63:0] off;
  logic [63:0] lim;

  always_comb begin
    off      = addr - BASE;
    lim      = 64'(DEPTH) - {60'd0, nbytes};
    in_range = (addr >= BASE) && (off <= lim) && (nbytes != 4'd0);
    idx      = off[IDX_W-1:0];
  end
endmodule

// File: rtl/lemp_bank.sv
module lemp_bank #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned A_LANES = 8,
  parameter int unsigned B_LANES = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic [A_LANES-1:0]     wr_lane,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [8*A_LANES-1:0]   wr_data,
  input  logic [IDX_W-1:0]       ra_idx,
  output logic [8*A_LANES-1:0]   ra_bytes,
  input  logic [IDX_W-1:0]       rb_idx,
  output logic [8*B_LANES-1:0]   rb_bytes
);
  logic [7:0] mem [DEPTH];

  // storage has no reset; lanes write on the accepting edge
  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(A_LANES); k++) begin
      if (wr_lane[k]) mem[wr_idx + IDX_W'(k)] <= wr_data[8*k +: 8];
    end
  end

  for (genvar k = 0; k < int'(A_LANES); k++) begin : g_ra
    assign ra_bytes[8*k +: 8] = mem[ra_idx + IDX_W'(k)];
  end

  for (genvar k = 0; k < int'(B_LANES); k++) begin : g_rb
    assign rb_bytes[8*k +: 8] = mem[rb_idx + IDX_W'(k)];
  end
endmodule

// File: rtl/lemp_pack.sv
module lemp_pack #(
  parameter int unsigned LANES = 8
) (
  input  logic [8*LANES-1:0] raw,
  input  logic [3:0]         nbytes,
  output logic [8*LANES-1:0] value
);
  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    assign value[8*k +: 8] = (32'(k) < {28'd0, nbytes}) ? raw[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/lemp_port.sv
module lemp_port #(
  parameter logic [63:0] BASE  = 64'h8000_0000,
  parameter int unsigned DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_req,
  input  logic [63:0] fetch_pc,
  output logic        fetch_vld,
  output logic [31:0] fetch_insn,
  output logic        fetch_fault,
  input  logic        dat_req,
  input  logic        dat_we,
  input  logic [63:0] dat_addr,
  input  logic [2:0]  dat_size,
  input  logic [63:0] dat_wdata,
  output logic        dat_vld,
  output logic [63:0] dat_rdata,
  output logic        dat_fault,
  output logic [63:0] stack_top
);
  import lemp_pkg::*;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned F_LANES = 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign stack_top = BASE + 64'(DEPTH);

  // data side decode
  logic [3:0]       d_nb;
  logic             d_szok;
  logic             d_inr;
  logic [IDX_W-1:0] d_idx;
  assign d_nb   = size_bytes(dat_size);
  assign d_szok = size_ok(dat_size);

  lemp_range #(.BASE(BASE), .DEPTH(DEPTH)) u_drange (
    .addr(dat_addr), .nbytes(d_nb), .in_range(d_inr), .idx(d_idx)
  );

  // fetch side decode
  logic             f_inr;
  logic [IDX_W-1:0] f_idx;
  lemp_range #(.BASE(BASE), .DEPTH(DEPTH)) u_frange (
    .addr(fetch_pc), .nbytes(4'(F_LANES)), .in_range(f_inr), .idx(f_idx)
  );

  // write lanes
  logic             wr_go;
  logic [LANES-1:0] wr_lane;
  assign wr_go = rst_int_n && dat_req && dat_we && d_szok && d_inr;
  for (genvar k = 0; k < int'(LANES); k++) begin : g_wl
    assign wr_lane[k] = wr_go && (32'(k) < {28'd0, d_nb});
  end

  logic [8*LANES-1:0]   ra_bytes;
  logic [8*F_LANES-1:0] rb_bytes;
  lemp_bank #(.DEPTH(DEPTH), .A_LANES(LANES), .B_LANES(F_LANES)) u_bank (
    .clk(clk), .wr_lane(wr_lane), .wr_idx(d_idx), .wr_data(dat_wdata),
    .ra_idx(d_idx), .ra_bytes(ra_bytes), .rb_idx(f_idx), .rb_bytes(rb_bytes)
  );

  logic [63:0] d_load;
  lemp_pack #(.LANES(LANES)) u_dpack (
    .raw(ra_bytes), .nbytes(d_nb), .value(d_load)
  );

  // next-state
  logic        dat_vld_d, dat_fault_d, dat_en;
  logic [63:0] dat_rdata_d;
  logic        fetch_vld_d, fetch_fault_d, fetch_en;
  logic [31:0] fetch_insn_d;

  always_comb begin
    dat_vld_d   = dat_req;
    dat_fault_d = 1'b0;
    dat_rdata_d = 64'd0;
    if (dat_req) begin
      if (!d_szok)     dat_rdata_d = dat_we ? 64'd0 : BAD_SIZE_CODE;
      else if (!d_inr) dat_fault_d = 1'b1;
      else if (!dat_we) dat_rdata_d = d_load;
    end
    dat_en = dat_req | dat_vld;

    fetch_vld_d   = fetch_req;
    fetch_fault_d = fetch_req && !f_inr;
    fetch_insn_d  = (fetch_req && f_inr) ? rb_bytes : 32'd0;
    fetch_en      = fetch_req | fetch_vld;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dat_vld   <= 1'b0;
      dat_fault <= 1'b0;
      dat_rdata <= 64'd0;
    end else begin
      dat_vld <= dat_vld_d;
      if (dat_en) begin
        dat_fault <= dat_fault_d;
        dat_rdata <= dat_rdata_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fetch_vld   <= 1'b0;
      fetch_fault <= 1'b0;
      fetch_insn  <= 32'd0;
    end else begin
      fetch_vld <= fetch_vld_d;
      if (fetch_en) begin
        fetch_fault <= fetch_fault_d;
        fetch_insn  <= fetch_insn_d;
      end
    end
  end
endmodule

// File: rtl/lemp_port_chk.sv
module lemp_port_chk #(
  parameter logic [63:0] BASE = 64'h8000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic [63:0] fetch_pc,
  input logic        fetch_vld,
  input logic [31:0] fetch_insn,
  input logic        fetch_fault,
  input logic        dat_req,
  input logic        dat_we,
  input logic [2:0]  dat_size,
  input logic        dat_vld,
  input logic [63:0] dat_rdata,
  input logic        dat_fault
);
  // R7
  dat_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req |=> dat_vld);
  // R7
  dat_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_req |=> !dat_vld);
  // R7
  fetch_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> fetch_vld);
  // R5
  dat_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_fault |-> (dat_rdata == 64'd0));
  // R4
  bad_size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && !dat_we && dat_size[2]) |=> (dat_rdata == 64'd1 && !dat_fault));
  // R2
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && !dat_we && dat_size == 3'd0) |=> (dat_rdata[63:8] == 56'd0));
  // R6
  fetch_low_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_pc < BASE) |=> (fetch_fault && fetch_insn == 32'd0));
endmodule

bind lemp_port lemp_port_chk #(.BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .fetch_req(fetch_req), .fetch_pc(fetch_pc), .fetch_vld(fetch_vld),
  .fetch_insn(fetch_insn), .fetch_fault(fetch_fault),
  .dat_req(dat_req), .dat_we(dat_we), .dat_size(dat_size),
  .dat_vld(dat_vld), .dat_rdata(dat_rdata), .dat_fault(dat_fault)
);

// File: tb/lemp_port_tb.sv
`timescale 1ns/1ps
module lemp_port_tb;
  localparam logic [63:0] BASE  = 64'h8000_0000;
  localparam int unsigned DEPTH = 2048;

  logic        clk, rst_n;
  logic        fetch_req, fetch_vld, fetch_fault;
  logic [63:0] fetch_pc;
  logic [31:0] fetch_insn;
  logic        dat_req, dat_we, dat_vld, dat_fault;
  logic [63:0] dat_addr, dat_wdata, dat_rdata, stack_top;
  logic [2:0]  dat_size;

  lemp_port #(.BASE(BASE), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc), .fetch_vld(fetch_vld),
    .fetch_insn(fetch_insn), .fetch_fault(fetch_fault),
    .dat_req(dat_req), .dat_we(dat_we), .dat_addr(dat_addr), .dat_size(dat_size),
    .dat_wdata(dat_wdata), .dat_vld(dat_vld), .dat_rdata(dat_rdata),
    .dat_fault(dat_fault), .stack_top(stack_top)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(logic [2:0] s);
    return s[2] ? 0 : (1 << s);
  endfunction

  function automatic bit in_rng(logic [63:0] a, int nb);
    return (a >= BASE) && ((a - BASE) <= 64'(DEPTH - nb));
  endfunction

  function automatic logic [63:0] mload(logic [63:0] a, int nb);
    logic [63:0] v = 64'd0;
    int base_i = int'(a - BASE);
    for (int b = 0; b < nb; b++) v[8*b +: 8] = model[base_i + b];
    return v;
  endfunction

  // one request cycle; entered and left at a falling edge
  task automatic op(bit fr, logic [63:0] pc, bit dr, bit we, logic [63:0] a,
                    logic [2:0] sz, logic [63:0] wd);
    int nb;
    logic [63:0] e_rd;
    logic e_df, e_ff;
    logic [31:0] e_fi;
    string tg;
    fetch_req = fr; fetch_pc = pc;
    dat_req = dr; dat_we = we; dat_addr = a; dat_size = sz; dat_wdata = wd;
    nb = nb_of(sz);
    e_rd = 64'd0; e_df = 1'b0; tg = "R1";
    if (nb == 0) begin e_rd = we ? 64'd0 : 64'd1; tg = "R4"; end
    else if (!in_rng(a, nb)) begin e_df = 1'b1; tg = "R5"; end
    else if (we) tg = "R3";
    else e_rd = mload(a, nb);
    e_ff = !in_rng(pc, 4);
    e_fi = e_ff ? 32'd0 : mload(pc, 4)[31:0];
    @(posedge clk);
    if (dr && we && nb != 0 && in_rng(a, nb))
      for (int b = 0; b < nb; b++) model[int'(a - BASE) + b] = wd[8*b +: 8];
    @(negedge clk);
    check("R7 dat_vld", {63'd0, dat_vld}, {63'd0, dr});
    check("R7 fetch_vld", {63'd0, fetch_vld}, {63'd0, fr});
    if (dr) begin
      check({tg, " data"}, dat_rdata, e_rd);
      check({tg, " fault"}, {63'd0, dat_fault}, {63'd0, e_df});
    end
    if (fr) begin
      check("R6 insn", {32'd0, fetch_insn}, {32'd0, e_fi});
      check("R6 fault", {63'd0, fetch_fault}, {63'd0, e_ff});
    end
  endtask

  function automatic logic [63:0] rand_addr();
    int r = int'($urandom % 16);
    if (r == 0) return BASE - 64'(1 + $urandom % 16);
    if (r == 1) return BASE + 64'(DEPTH) - 64'($urandom % 10);
    if (r == 2) return BASE + 64'h1_0000_0000 + 64'($urandom);
    return BASE + 64'($urandom % DEPTH);
  endfunction

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    fetch_req = 0; fetch_pc = 0; dat_req = 0; dat_we = 0;
    dat_addr = 0; dat_size = 0; dat_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 dat_vld", {63'd0, dat_vld}, 64'd0);
    check("R9 fetch_vld", {63'd0, fetch_vld}, 64'd0);
    check("R9 faults", {62'd0, dat_fault, fetch_fault}, 64'd0);
    // R8
    check("R8 stack_top", stack_top, 64'h8000_0800);

    // fill memory so the model is fully known
    for (int i = 0; i < int'(DEPTH / 8); i++)
      op(0, 0, 1, 1, BASE + 64'(8 * i), 3'd3, {$urandom, $urandom});

    // R1 little-endian assembly with distinct bytes
    op(0, 0, 1, 1, BASE + 64'd16, 3'd3, 64'h8877_6655_4433_2211);
    op(0, 0, 1, 0, BASE + 64'd16, 3'd3, 0);
    check("R1 dword literal", dat_rdata, 64'h8877_6655_4433_2211);
    op(0, 0, 1, 0, BASE + 64'd17, 3'd0, 0);
    check("R1 R2 byte literal", dat_rdata, 64'h22);
    op(0, 0, 1, 0, BASE + 64'd18, 3'd1, 0);
    check("R1 R2 half literal", dat_rdata, 64'h4433);
    op(0, 0, 1, 0, BASE + 64'd20, 3'd2, 0);
    check("R1 R2 word literal", dat_rdata, 64'h8877_6655);
    // R3 partial stores leave neighbours alone
    op(0, 0, 1, 1, BASE + 64'd17, 3'd0, 64'hFFFF_FFFF_FFFF_FFAA);
    op(0, 0, 1, 1, BASE + 64'd20, 3'd1, 64'hFFFF_FFFF_FFFF_CCBB);
    op(0, 0, 1, 0, BASE + 64'd16, 3'd3, 0);
    check("R3 partial store", dat_rdata, 64'h8877_CCBB_4433_AA11);
    // R4 unsupported size: load gives 1, store writes nothing
    op(0, 0, 1, 0, BASE + 64'd16, 3'd5, 0);
    op(0, 0, 1, 1, BASE + 64'd16, 3'd6, 64'h0);
    op(0, 0, 1, 0, BASE + 64'd16, 3'd3, 0);
    check("R4 store ignored", dat_rdata, 64'h8877_CCBB_4433_AA11);
    // R5 range edges
    op(0, 0, 1, 0, BASE - 64'd1, 3'd0, 0);
    op(0, 0, 1, 0, BASE + 64'(DEPTH) - 64'd8, 3'd3, 0);
    op(0, 0, 1, 0, BASE + 64'(DEPTH) - 64'd7, 3'd3, 0);
    op(0, 0, 1, 1, BASE + 64'(DEPTH) - 64'd1, 3'd1, 64'h5A5A);
    op(0, 0, 1, 0, BASE, 3'd3, 0);
    // R6 fetch edges
    op(1, BASE + 64'd16, 0, 0, 0, 0, 0);
    check("R6 fetch literal", {32'd0, fetch_insn}, 64'h4433_AA11);
    op(1, BASE + 64'(DEPTH) - 64'd4, 0, 0, 0, 0, 0);
    op(1, BASE + 64'(DEPTH) - 64'd3, 0, 0, 0, 0, 0);
    // R7 store and fetch at one address in one cycle: fetch sees old word
    op(1, BASE + 64'd16, 1, 1, BASE + 64'd16, 3'd2, 64'hDEAD_BEEF);
    check("R7 same-cycle old", {32'd0, fetch_insn}, 64'h4433_AA11);
    op(1, BASE + 64'd16, 0, 0, 0, 0, 0);
    check("R7 next-cycle new", {32'd0, fetch_insn}, 64'hDEAD_BEEF);
    op(0, 0, 0, 0, 0, 0, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] sz = (($urandom % 8) == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      op(($urandom % 2) == 1, rand_addr(), ($urandom % 4) != 0, ($urandom % 2) == 1,
         rand_addr(), sz, {$urandom, $urandom});
    end
    op(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule